// File: doc/BRIEF.md
# Quadword Block-Copy DMA Channel

This block is a single DMA channel that copies a contiguous run of 128-bit quadwords from a source address to a destination address. Software programs the number of quadwords, the source byte address and a destination byte address, then writes the control register with its start bit set. The destination address that reaches memory is the programmed value placed inside a fixed destination window. The window base is added to it by default, or OR-ed in when a parameter selects that variant.

The channel drives a memory master port with a valid/ready request handshake. Each quadword takes one read request, one read response and one write request. When the last quadword has been written, the channel clears its own start bit and quadword count and sets its bit in an interrupt status half. An interrupt line is raised while any status bit is set whose mask bit is also set. The status half is write-one-to-clear. The mask half has its own register and is never changed by writes to the status register.

Registers are 32 bits wide and sit in 16-byte slots. Writes to an offset whose low four bits are not zero are dropped, and reads from such an offset return zero.

Top module: `qw_copy_dma`

## Requirements
- R1: After reset every register reads zero, `dma_irq` is low and `mem_req_valid` is low.
- R2: The register slots are at these byte offsets:
  - 0x00 control; bit 8 is the start bit.
  - 0x10 quadword count.
  - 0x20 source address.
  - 0x30 destination address.
  - 0x40 interrupt register.
  - 0x50 interrupt mask.

  While the channel is idle, control, count, source, destination and mask read back what was written. Unused slots read zero. Offsets whose low nibble is not zero ignore writes and read zero.
- R3: Writing control with bit 8 set while idle starts a copy of count×16 bytes. Quadword i is read from source+16·i and written to destination+DST_BASE+16·i. No other memory location is written.
- R4: Completion happens on the second clock edge after the final write handshake. After it, the count reads zero and control bit 8 reads zero, while the source and destination registers keep their programmed values.
- R5: The interrupt register reads status in bits [15:0] and mask in bits [31:16]. Writing it clears each status bit whose data bit is 1, and leaves the mask unchanged. The mask is written only through offset 0x50, from bits [15:0].
- R6: Completion sets status bit 2. `dma_irq` is high exactly when (status AND mask) is non-zero, so it also follows a later mask write or status clear.
- R7: Every quadword uses exactly one read request and one write request. A request that is not accepted holds its valid, address and direction stable until `mem_req_ready` is high.
- R8: While a transfer is in progress, every register write except a control write with bit 8 clear has no effect. This includes a second start and writes to the interrupt register.
- R9: A control write with bit 8 clear during a transfer stops the channel after the quadword in flight is written. The count is not cleared, the status bit is not set, and control takes the written value.
- R10: Starting with a count of zero completes on the next edge with no memory traffic. It still clears the start bit and sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_OFS_W | Register byte offset (read and write) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DATA_W | Read data |
| dma_irq | output | 1 | Interrupt, high while status AND mask is non-zero |

## Verification
The first read request is valid in the cycle after the edge that takes the start write. Each further request follows its predecessor's handshake or read response by one edge. The count clear, the start-bit clear and the status bit, and with it `dma_irq`, all change together on the second edge after the final write handshake. A mask change or status clear reaches `dma_irq` on the edge that takes the write. The bench drives every input on the falling edge and samples on the falling edge. It stamps the cycle of each accepted write in its memory model and checks that the start bit is first seen clear exactly two cycles after the last write stamp, with `dma_irq` checked in that same sample.

// File: rtl/qcd_pkg.sv
package qcd_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RD_REQ,
      SQ_RD_WAIT,
      SQ_WR_REQ,
      SQ_FINISH
   } seq_state_e;

   localparam int SLOT_CTRL  = 0;
   localparam int SLOT_QWC   = 1;
   localparam int SLOT_SRC   = 2;
   localparam int SLOT_DST   = 3;
   localparam int SLOT_ISTAT = 4;
   localparam int SLOT_IMASK = 5;

   localparam int STAT_HALF_W = 16;

endpackage

// File: rtl/qcd_regs.sv
module qcd_regs
   import qcd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter int SLOT_W    = 4,
   parameter int START_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] slot,
   input  logic [31:0]       wdata,
   input  logic              busy,
   input  logic              done,
   output logic              launch,
   output logic              halt,
   output logic [CNT_W-1:0]  qwc_q,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [31:0]       rdata
);

   logic [31:0] ctrl_q;
   logic        is_ctrl;
   logic        accept;

   assign is_ctrl = (slot == SLOT_W'(SLOT_CTRL));
   assign launch  = wr_en && is_ctrl && wdata[START_BIT] && !busy;
   assign halt    = wr_en && is_ctrl && !wdata[START_BIT] && busy;
   assign accept  = wr_en && (!busy || halt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         qwc_q  <= '0;
         src_q  <= '0;
         dst_q  <= '0;
      end else if (done) begin
         ctrl_q[START_BIT] <= 1'b0;
         qwc_q             <= '0;
      end else if (accept) begin
         case (slot)
            SLOT_W'(SLOT_CTRL): ctrl_q <= wdata;
            SLOT_W'(SLOT_QWC):  qwc_q  <= wdata[CNT_W-1:0];
            SLOT_W'(SLOT_SRC):  src_q  <= wdata[ADDR_W-1:0];
            SLOT_W'(SLOT_DST):  dst_q  <= wdata[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (slot)
         SLOT_W'(SLOT_CTRL): rdata = ctrl_q;
         SLOT_W'(SLOT_QWC):  rdata = 32'(qwc_q);
         SLOT_W'(SLOT_SRC):  rdata = 32'(src_q);
         SLOT_W'(SLOT_DST):  rdata = 32'(dst_q);
         default:            rdata = '0;
      endcase
   end

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!ctrl_q[START_BIT] && qwc_q == '0)); // R4
   AST_BUSY_SRC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && slot == SLOT_W'(SLOT_SRC)) |=> $stable(src_q)); // R8
   AST_BUSY_QWC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && wr_en && slot == SLOT_W'(SLOT_QWC)) |=> $stable(qwc_q)); // R8

endmodule

// File: rtl/qcd_seq.sv
module qcd_seq
   import qcd_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          DATA_W      = 128,
   parameter int          CNT_W       = 16,
   parameter logic [31:0] DST_BASE    = 32'h0000_0400,
   parameter int          WINDOW_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              halt,
   input  logic [CNT_W-1:0]  qwc,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic              busy,
   output logic              done
);

   localparam int               QW_BYTES = DATA_W / 8;
   localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(QW_BYTES);
   localparam logic [ADDR_W-1:0] BASE    = DST_BASE[ADDR_W-1:0];

   seq_state_e        state;
   logic [ADDR_W-1:0] rd_addr;
   logic [ADDR_W-1:0] wr_addr;
   logic [CNT_W-1:0]  remain;
   logic [DATA_W-1:0] qw_buf;
   logic              stop_pend;
   logic [ADDR_W-1:0] dst_phys;

   if (WINDOW_MODE == 0) begin : g_win_add
      assign dst_phys = dst + BASE;
   end else begin : g_win_or
      assign dst_phys = dst | BASE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         rd_addr   <= '0;
         wr_addr   <= '0;
         remain    <= '0;
         qw_buf    <= '0;
         stop_pend <= 1'b0;
      end else begin
         if (halt) stop_pend <= 1'b1;
         case (state)
            SQ_IDLE: begin
               if (launch) begin
                  rd_addr   <= src;
                  wr_addr   <= dst_phys;
                  remain    <= qwc;
                  stop_pend <= 1'b0;
                  state     <= (qwc == '0) ? SQ_FINISH : SQ_RD_REQ;
               end
            end
            SQ_RD_REQ: begin
               if (mem_req_ready) state <= SQ_RD_WAIT;
            end
            SQ_RD_WAIT: begin
               if (mem_rsp_valid) begin
                  qw_buf <= mem_rsp_rdata;
                  state  <= SQ_WR_REQ;
               end
            end
            SQ_WR_REQ: begin
               if (mem_req_ready) begin
                  rd_addr <= rd_addr + STEP;
                  wr_addr <= wr_addr + STEP;
                  remain  <= remain - CNT_W'(1);
                  if (remain == CNT_W'(1))        state <= SQ_FINISH;
                  else if (stop_pend || halt)     state <= SQ_IDLE;
                  else                            state <= SQ_RD_REQ;
               end
            end
            SQ_FINISH: state <= SQ_IDLE;
            default:   state <= SQ_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state == SQ_RD_REQ) || (state == SQ_WR_REQ);
   assign mem_req_write = (state == SQ_WR_REQ);
   assign mem_req_addr  = (state == SQ_WR_REQ) ? wr_addr : rd_addr;
   assign mem_req_wdata = qw_buf;
   assign busy          = (state != SQ_IDLE);
   assign done          = (state == SQ_FINISH);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R7
   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(mem_req_valid && mem_req_write && mem_req_ready) || $past(launch))); // R4
   AST_LAUNCH_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !busy) |=> (busy && !mem_req_write)); // R3

endmodule

// File: rtl/qcd_irq.sv
module qcd_irq
   import qcd_pkg::*;
#(
   parameter int SLOT_W   = 4,
   parameter int STAT_BIT = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SLOT_W-1:0]      slot,
   input  logic [STAT_HALF_W-1:0] wdata,
   input  logic                   busy,
   input  logic                   done,
   output logic                   irq,
   output logic [31:0]            rdata
);

   logic [STAT_HALF_W-1:0] status;
   logic [STAT_HALF_W-1:0] mask_q;
   logic                   wr_stat;
   logic                   wr_mask;

   assign wr_stat = wr_en && !busy && (slot == SLOT_W'(SLOT_ISTAT));
   assign wr_mask = wr_en && !busy && (slot == SLOT_W'(SLOT_IMASK));

   for (genvar gi = 0; gi < STAT_HALF_W; gi++) begin : g_stat
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          bit_q <= 1'b0;
         else if (done && gi == STAT_BIT)     bit_q <= 1'b1;
         else if (wr_stat && wdata[gi])       bit_q <= 1'b0;
      end
      assign status[gi] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= wdata;
   end

   assign irq = |(status & mask_q);

   always_comb begin
      case (slot)
         SLOT_W'(SLOT_ISTAT): rdata = {mask_q, status};
         SLOT_W'(SLOT_IMASK): rdata = {{(32-STAT_HALF_W){1'b0}}, mask_q};
         default:             rdata = '0;
      endcase
   end

   AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && slot == SLOT_W'(SLOT_ISTAT)) |=> $stable(mask_q)); // R5
   AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[STAT_BIT]) |-> $past(done)); // R6
   AST_BUSY_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> ((status & $past(status)) == $past(status))); // R8

endmodule

// File: rtl/qw_copy_dma.sv
module qw_copy_dma
   import qcd_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          DATA_W      = 128,
   parameter int          CNT_W       = 16,
   parameter int          REG_OFS_W   = 8,
   parameter int          START_BIT   = 8,
   parameter int          STAT_BIT    = 2,
   parameter logic [31:0] DST_BASE    = 32'h0000_0400,
   parameter int          WINDOW_MODE = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [REG_OFS_W-1:0] cfg_addr,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic                 mem_req_write,
   output logic [ADDR_W-1:0]    mem_req_addr,
   output logic [DATA_W-1:0]    mem_req_wdata,
   input  logic                 mem_rsp_valid,
   input  logic [DATA_W-1:0]    mem_rsp_rdata,
   output logic                 dma_irq
);

   localparam int SLOT_W = REG_OFS_W - 4;

   if (DATA_W != 128)               begin : g_bad_data  $error("DATA_W must be 128");            end
   if (ADDR_W < 12 || ADDR_W > 32)  begin : g_bad_addr  $error("ADDR_W must be 12..32");         end
   if (CNT_W < 1 || CNT_W > 32)     begin : g_bad_cnt   $error("CNT_W must be 1..32");           end
   if (REG_OFS_W < 7)               begin : g_bad_ofs   $error("REG_OFS_W must be at least 7");  end
   if (START_BIT < 0 || START_BIT > 31) begin : g_bad_start $error("START_BIT out of range");     end
   if (STAT_BIT < 0 || STAT_BIT >= STAT_HALF_W) begin : g_bad_stat $error("STAT_BIT out of range"); end
   if (WINDOW_MODE < 0 || WINDOW_MODE > 1) begin : g_bad_win $error("WINDOW_MODE must be 0 or 1"); end

   logic              aligned;
   logic              wr_en;
   logic [SLOT_W-1:0] slot;
   logic              launch;
   logic              halt;
   logic              busy;
   logic              done;
   logic [CNT_W-1:0]  qwc_q;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic [31:0]       regs_rdata;
   logic [31:0]       irq_rdata;

   assign aligned = (cfg_addr[3:0] == 4'h0);
   assign wr_en   = cfg_we && aligned;
   assign slot    = cfg_addr[REG_OFS_W-1:4];

   qcd_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W), .START_BIT(START_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot(slot), .wdata(cfg_wdata),
      .busy(busy), .done(done), .launch(launch), .halt(halt),
      .qwc_q(qwc_q), .src_q(src_q), .dst_q(dst_q), .rdata(regs_rdata)
   );

   qcd_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .DST_BASE(DST_BASE), .WINDOW_MODE(WINDOW_MODE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .halt(halt),
      .qwc(qwc_q), .src(src_q), .dst(dst_q),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .busy(busy), .done(done)
   );

   qcd_irq #(
      .SLOT_W(SLOT_W), .STAT_BIT(STAT_BIT)
   ) u_irq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot(slot),
      .wdata(cfg_wdata[STAT_HALF_W-1:0]), .busy(busy), .done(done),
      .irq(dma_irq), .rdata(irq_rdata)
   );

   assign cfg_rdata = aligned ? (regs_rdata | irq_rdata) : 32'h0;

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!mem_req_valid && !dma_irq)); // R1
   AST_STOP_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !done) |=> !done || $past(mem_req_valid && mem_req_write && mem_req_ready)); // R9

endmodule

// File: tb/qw_copy_dma_bench.sv
`timescale 1ns/1ps
module qw_copy_dma_bench;

   localparam logic [7:0] A_CTRL  = 8'h00;
   localparam logic [7:0] A_QWC   = 8'h10;
   localparam logic [7:0] A_SRC   = 8'h20;
   localparam logic [7:0] A_DST   = 8'h30;
   localparam logic [7:0] A_ISTAT = 8'h40;
   localparam logic [7:0] A_IMASK = 8'h50;
   localparam logic [31:0] START  = 32'h0000_0100;
   localparam logic [31:0] STATB  = 32'h0000_0004;
   localparam int          WIN_QW = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [7:0]   cfg_addr = '0;
   logic [31:0]  cfg_wdata = '0;
   logic [31:0]  cfg_rdata;
   logic         mem_req_valid;
   logic         mem_req_ready = 1'b1;
   logic         mem_req_write;
   logic [31:0]  mem_req_addr;
   logic [127:0] mem_req_wdata;
   logic         mem_rsp_valid = 1'b0;
   logic [127:0] mem_rsp_rdata = '0;
   logic         dma_irq;

   int  n_checks = 0;
   int  n_errors = 0;
   int  cyc = 0;
   int  last_wr_cyc = 0;
   int  n_rd = 0;
   int  n_wr = 0;
   bit  rdy_rand = 1'b0;
   bit  finished = 1'b0;
   logic [127:0] mem [0:255];
   logic [127:0] pre [0:255];

   always #2.5 clk = ~clk;

   qw_copy_dma u_qw_copy_dma (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .dma_irq(dma_irq)
   );

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            mem[mem_req_addr[11:4]] <= mem_req_wdata;
            n_wr <= n_wr + 1;
            last_wr_cyc <= cyc;
         end else begin
            mem_rsp_rdata <= mem[mem_req_addr[11:4]];
            mem_rsp_valid <= 1'b1;
            n_rd <= n_rd + 1;
         end
      end
   end

   always @(negedge clk)
      mem_req_ready <= rdy_rand ? (($urandom % 4) != 0) : 1'b1;

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #0.5 d = cfg_rdata;
   endtask

   task automatic fill_mem();
      for (int i = 0; i < 256; i++) mem[i] = {$urandom, $urandom, $urandom, $urandom};
   endtask

   // poll control until start clears; returns cycles since last write stamp
   task automatic wait_clear(output bit ok, output int gap);
      logic [31:0] v;
      ok = 1'b0; gap = -1;
      for (int i = 0; i < 3000; i++) begin
         cfg_read(A_CTRL, v);
         if (!v[8]) begin ok = 1'b1; gap = cyc - last_wr_cyc; break; end
      end
   endtask

   task automatic run_job(input int qwc, input int s, input int d, input bit mask_on);
      logic [31:0] v;
      bit ok; int gap; int rd0; int wr0; int bad;
      cfg_write(A_IMASK, mask_on ? STATB : 32'h0);
      cfg_write(A_QWC, 32'(qwc));
      cfg_write(A_SRC, 32'(s * 16));
      cfg_write(A_DST, 32'(d * 16));
      for (int i = 0; i < 256; i++) pre[i] = mem[i];
      rd0 = n_rd; wr0 = n_wr;
      cfg_write(A_CTRL, START);
      wait_clear(ok, gap);
      chk("R4 start bit clears", 64'(ok), 64'(1));
      chk("R6 irq at completion", 64'(dma_irq), 64'(mask_on));
      if (qwc > 0) chk("R4 completion two cycles after last write", 64'(gap), 64'(2));
      cfg_read(A_QWC, v);  chk("R4 count reads zero", 64'(v), 64'(0));
      cfg_read(A_SRC, v);  chk("R4 source kept", 64'(v), 64'(s * 16));
      cfg_read(A_DST, v);  chk("R4 destination kept", 64'(v), 64'(d * 16));
      bad = 0;
      for (int i = 0; i < qwc; i++)
         if (mem[WIN_QW + d + i] !== pre[s + i]) bad++;
      chk("R3 copied quadwords", 64'(bad), 64'(0));
      bad = 0;
      for (int i = 0; i < 256; i++)
         if ((i < WIN_QW + d || i >= WIN_QW + d + qwc) && mem[i] !== pre[i]) bad++;
      chk("R3 nothing else written", 64'(bad), 64'(0));
      chk("R7 read count", 64'(n_rd - rd0), 64'(qwc));
      chk("R7 write count", 64'(n_wr - wr0), 64'(qwc));
      cfg_read(A_ISTAT, v);
      chk("R5 status and mask halves", 64'(v), 64'({(mask_on ? 16'h0004 : 16'h0), 16'h0004}));
      cfg_write(A_ISTAT, 32'hFFFF_FFFF);
      cfg_read(A_ISTAT, v);
      chk("R5 w1c keeps mask", 64'(v), 64'({(mask_on ? 16'h0004 : 16'h0), 16'h0000}));
      chk("R6 irq after clear", 64'(dma_irq), 64'(0));
   endtask

   initial begin
      logic [31:0] v;
      int rd0; int wr0; int q; int s; int d;
      bit ok; int gap;
      void'($urandom(32'd20240611));
      fill_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < 6; k++) begin
         cfg_read(8'(k * 16), v);
         chk("R1 register reset value", 64'(v), 64'(0));
      end
      chk("R1 irq low", 64'(dma_irq), 64'(0));
      chk("R1 no request", 64'(mem_req_valid), 64'(0));

      // R2 register map and readback
      cfg_write(A_QWC, 32'h0000_1234); cfg_read(A_QWC, v);
      chk("R2 count readback", 64'(v), 64'(32'h1234));
      cfg_write(A_SRC, 32'hDEAD_BEE0); cfg_read(A_SRC, v);
      chk("R2 source readback", 64'(v), 64'(32'hDEAD_BEE0));
      cfg_write(A_DST, 32'h0000_0120); cfg_read(A_DST, v);
      chk("R2 destination readback", 64'(v), 64'(32'h120));
      cfg_write(A_CTRL, 32'h0000_0005); cfg_read(A_CTRL, v);
      chk("R2 control readback", 64'(v), 64'(32'h5));
      cfg_write(A_IMASK, 32'hABCD_00FF); cfg_read(A_IMASK, v);
      chk("R2 mask readback", 64'(v), 64'(32'h00FF));
      cfg_read(A_ISTAT, v);
      chk("R5 mask in upper half", 64'(v), 64'(32'h00FF_0000));
      cfg_write(8'h14, 32'h0000_0077); cfg_read(A_QWC, v);
      chk("R2 misaligned write dropped", 64'(v), 64'(32'h1234));
      cfg_read(8'h14, v);
      chk("R2 misaligned read zero", 64'(v), 64'(0));
      cfg_read(8'h60, v);
      chk("R2 unused slot zero", 64'(v), 64'(0));

      // directed: single quadword, full ready
      run_job(1, 0, 0, 1'b1);
      // random jobs with random ready
      rdy_rand = 1'b1;
      for (int t = 0; t < 8; t++) begin
         q = 1 + ($urandom % 12);
         s = $urandom % (WIN_QW - q);
         d = $urandom % (WIN_QW - 1 - q);
         run_job(q, s, d, ($urandom % 2) == 0);
      end

      // R6 mask applied after status is set
      cfg_write(A_IMASK, 32'h0);
      cfg_write(A_QWC, 32'd2); cfg_write(A_SRC, 32'h0); cfg_write(A_DST, 32'h0);
      cfg_write(A_CTRL, START);
      wait_clear(ok, gap);
      chk("R6 irq masked off", 64'(dma_irq), 64'(0));
      cfg_write(A_IMASK, STATB);
      chk("R6 irq follows mask write", 64'(dma_irq), 64'(1));
      cfg_write(A_ISTAT, STATB);
      chk("R6 irq drops on clear", 64'(dma_irq), 64'(0));

      // R10 zero count
      rd0 = n_rd; wr0 = n_wr;
      cfg_write(A_QWC, 32'd0);
      cfg_write(A_CTRL, START);
      wait_clear(ok, gap);
      chk("R10 zero count completes", 64'(ok), 64'(1));
      chk("R10 no memory traffic", 64'((n_rd - rd0) + (n_wr - wr0)), 64'(0));
      cfg_read(A_ISTAT, v);
      chk("R10 status set", 64'(v[15:0]), 64'(16'h0004));
      cfg_write(A_ISTAT, STATB);

      // R8 writes ignored while busy
      fill_mem();
      for (int i = 0; i < 256; i++) pre[i] = mem[i];
      rd0 = n_rd; wr0 = n_wr;
      cfg_write(A_QWC, 32'd20); cfg_write(A_SRC, 32'h30); cfg_write(A_DST, 32'h40);
      cfg_write(A_CTRL, START);
      cfg_write(A_SRC, 32'h777);
      cfg_write(A_DST, 32'h0);
      cfg_write(A_QWC, 32'd3);
      cfg_write(A_IMASK, 32'hFFFF);
      cfg_write(A_CTRL, START | 32'h1);
      wait_clear(ok, gap);
      cfg_read(A_SRC, v);   chk("R8 source write ignored", 64'(v), 64'(32'h30));
      cfg_read(A_DST, v);   chk("R8 destination write ignored", 64'(v), 64'(32'h40));
      cfg_read(A_IMASK, v); chk("R8 mask write ignored", 64'(v), 64'(32'h4));
      cfg_read(A_CTRL, v);  chk("R8 restart ignored", 64'(v), 64'(0));
      chk("R8 full length copied", 64'(n_wr - wr0), 64'(20));
      chk("R8 data from original source", 64'(mem[WIN_QW + 4 + 19] === pre[3 + 19]), 64'(1));
      cfg_write(A_ISTAT, STATB);

      // R9 stop mid transfer
      fill_mem();
      for (int i = 0; i < 256; i++) pre[i] = mem[i];
      rd0 = n_rd; wr0 = n_wr;
      cfg_write(A_QWC, 32'd40); cfg_write(A_SRC, 32'h0); cfg_write(A_DST, 32'h0);
      cfg_write(A_CTRL, START);
      cfg_write(A_CTRL, 32'h0000_0010);
      repeat (60) @(negedge clk);
      cfg_read(A_CTRL, v);  chk("R9 control takes stop value", 64'(v), 64'(32'h10));
      cfg_read(A_QWC, v);   chk("R9 count not cleared", 64'(v), 64'(40));
      cfg_read(A_ISTAT, v); chk("R9 no status on stop", 64'(v[15:0]), 64'(0));
      chk("R9 irq low", 64'(dma_irq), 64'(0));
      chk("R9 in-flight quadword finished", 64'(n_wr - wr0), 64'(1));
      chk("R9 reads match writes", 64'(n_rd - rd0), 64'(1));
      chk("R9 tail untouched", 64'(mem[WIN_QW + 39] === pre[WIN_QW + 39]), 64'(1));

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule